// File: doc/BRIEF.md
# Programmable Integer Clock Divider Channel

This block is one output channel of a clock distribution tree. It runs on a fast input clock and produces a divided clock. The high and low halves of the divided clock are counted separately, so a duty cycle that is not 50 percent is easy to set. The divider can start high or low. A chip-wide restart strobe brings every channel that obeys it back to a common phase. A per-channel offset then delays the first half-period by a set number of input cycles, which staggers channels against one another.

Configuration reaches the channel as parallel fields, captured on a write strobe. Around the divider sit the output controls, in fixed priority:
- a power-down that holds the output low;
- a direct path that hands the raw input clock to the output, unless a chip-wide path select overrides it;
- a bypass that passes the input clock in place of the divided one;
- a static force level, which needs both the sync-ignore option and a separate enable strobe.

Top module: `cdiv_channel`

## Requirements
- R1: With low-count field L (4 bits, count minus one), every low half of the divided output lasts exactly L+1 input clock cycles.
- R2: With high-count field H (4 bits, count minus one), every high half of the divided output lasts exactly H+1 input clock cycles.
- R3: After reset the shadow configuration is: low count 3, high count RST_HIGH (default 3), start low, phase offset 0, and all option bits clear. The divider behaves as if restarted at the last reset cycle, so its first low half lasts 4 cycles.
- R4: With the sync-ignore bit set, the restart strobe has no effect on the running divider.
- R5: With the sync-ignore bit set and force_en high, the output is held at the force-level bit (0 low, 1 high) for as long as the strobe stays high.
- R6: While sync_req is high and the sync-ignore bit is clear, the divider holds its output at the start level: 0 is low, 1 is high. Counting restarts from the last cycle in which sync_req was high.
- R7: A phase offset P extends the first half after a restart by P input cycles.
- R8: With the bypass bit set, the output carries the input clock and the counters hold.
- R9: With chan_direct high and path_sel_glob low, the output carries the input clock. With path_sel_glob high, chan_direct has no effect.
- R10: With chan_pdn high, the output is low, overriding every other control.
- R11: A new high or low count takes effect at the next half-period boundary. A half that is already running keeps its old length.
- R12: The force-level bit has no effect without force_en, and force_en has no effect while the sync-ignore bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock, also the source for the pass-through paths |
| rst | input | 1 | Synchronous active-high reset |
| sync_req | input | 1 | Chip-wide restart strobe, active high |
| cfg_we | input | 1 | Captures all cfg_* fields into the shadow configuration |
| cfg_low | input | 4 | Low half length minus one |
| cfg_high | input | 4 | High half length minus one |
| cfg_phase | input | 4 | Extra input cycles added to the first half after a restart |
| cfg_bypass | input | 1 | Pass the input clock in place of the divided one |
| cfg_ign_sync | input | 1 | Ignore the restart strobe |
| cfg_frc_lvl | input | 1 | Static level used while forcing |
| cfg_start_hi | input | 1 | Level after restart or reset |
| force_en | input | 1 | Enables static forcing (needs sync-ignore) |
| chan_direct | input | 1 | Route the raw input clock to the output |
| chan_pdn | input | 1 | Power down the channel, output low |
| path_sel_glob | input | 1 | Chip-wide select that disables the direct path when high |
| clk_out | output | 1 | Channel output |

## Verification
The bench restarts the divider under several shapes: odd duty cycles, a 1-cycle high half, the longest low half, a start-high case and non-zero offsets. Each run is compared cycle by cycle with the waveform the fields imply. An off-by-one in either counter, or an offset that is applied every period or not at all, shifts the first edge and shows up at once.

Count changes are written both in the middle of a low half and in the middle of a high half. A design that reloads immediately would cut the running half short and emit a runt pulse. A restart pulse is sent while ignore is set, and the force bit is set without its strobe. A design that obeyed either one would bend the waveform.

The output-path tests sample at both clock phases, to tell a passed-through clock apart from a stuck level. They also check that power-down beats every other control and that the chip-wide select cancels the direct path.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
    localparam int CNT_W = 4;
    localparam int PH_W  = 4;
    localparam int SEQ_W = (CNT_W > PH_W) ? CNT_W : PH_W;

    typedef struct packed {
        logic [CNT_W-1:0] low;
        logic [CNT_W-1:0] high;
        logic [PH_W-1:0]  phase;
        logic             bypass;
        logic             ign_sync;
        logic             frc_lvl;
        logic             start_hi;
    } div_cfg_t;

    typedef enum logic [1:0] {
        DS_RUN   = 2'd0,
        DS_DELAY = 2'd1
    } div_st_t;

    function automatic logic [SEQ_W-1:0] half_len(input div_cfg_t c, input logic hi);
        return hi ? SEQ_W'(c.high) : SEQ_W'(c.low);
    endfunction
endpackage

// File: rtl/cdiv_cfg_reg.sv
module cdiv_cfg_reg
    import cdiv_pkg::*;
#(
    parameter int RST_LOW  = 3,
    parameter int RST_HIGH = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  div_cfg_t wr_cfg,
    output div_cfg_t sh_cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sh_cfg          <= '0;
            sh_cfg.low      <= CNT_W'(RST_LOW);
            sh_cfg.high     <= CNT_W'(RST_HIGH);
        end else if (we) begin
            sh_cfg <= wr_cfg;
        end
    end
endmodule

// File: rtl/cdiv_counter.sv
module cdiv_counter
    import cdiv_pkg::*;
#(
    parameter int RST_LOW  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_eff,
    input  div_cfg_t         sh_cfg,
    output logic             lvl,
    output div_st_t          st,
    output logic [SEQ_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lvl <= 1'b0;
            st  <= DS_RUN;
            cnt <= SEQ_W'(RST_LOW);
        end else if (sync_eff) begin
            lvl <= sh_cfg.start_hi;
            if (sh_cfg.phase == '0) begin
                st  <= DS_RUN;
                cnt <= half_len(sh_cfg, sh_cfg.start_hi);
            end else begin
                st  <= DS_DELAY;
                cnt <= SEQ_W'(sh_cfg.phase);
            end
        end else if (!sh_cfg.bypass) begin
            case (st)
                DS_DELAY: begin
                    if (cnt == SEQ_W'(1)) begin
                        st  <= DS_RUN;
                        cnt <= half_len(sh_cfg, lvl);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        lvl <= ~lvl;
                        cnt <= half_len(sh_cfg, ~lvl);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/cdiv_outmux.sv
module cdiv_outmux (
    input  logic clk_in,
    input  logic div_lvl,
    input  logic pdn,
    input  logic direct,
    input  logic glob_sel,
    input  logic bypass,
    input  logic ign_sync,
    input  logic frc_lvl,
    input  logic frc_en,
    output logic out
);
    always_comb begin
        if (pdn)
            out = 1'b0;
        else if (direct && !glob_sel)
            out = clk_in;
        else if (bypass)
            out = clk_in;
        else if (ign_sync && frc_en)
            out = frc_lvl;
        else
            out = div_lvl;
    end
endmodule

// File: rtl/cdiv_channel.sv
module cdiv_channel
    import cdiv_pkg::*;
#(
    parameter int RST_LOW  = 3,
    parameter int RST_HIGH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_req,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_low,
    input  logic [CNT_W-1:0] cfg_high,
    input  logic [PH_W-1:0]  cfg_phase,
    input  logic             cfg_bypass,
    input  logic             cfg_ign_sync,
    input  logic             cfg_frc_lvl,
    input  logic             cfg_start_hi,
    input  logic             force_en,
    input  logic             chan_direct,
    input  logic             chan_pdn,
    input  logic             path_sel_glob,
    output logic             clk_out
);
    div_cfg_t         wr_cfg;
    div_cfg_t         sh_cfg;
    logic             sync_eff;
    logic             div_lvl;
    div_st_t          core_st;
    logic [SEQ_W-1:0] core_cnt;

    always_comb begin
        wr_cfg.low      = cfg_low;
        wr_cfg.high     = cfg_high;
        wr_cfg.phase    = cfg_phase;
        wr_cfg.bypass   = cfg_bypass;
        wr_cfg.ign_sync = cfg_ign_sync;
        wr_cfg.frc_lvl  = cfg_frc_lvl;
        wr_cfg.start_hi = cfg_start_hi;
    end

    assign sync_eff = sync_req && !sh_cfg.ign_sync;

    cdiv_cfg_reg #(.RST_LOW(RST_LOW), .RST_HIGH(RST_HIGH)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .wr_cfg (wr_cfg),
        .sh_cfg (sh_cfg)
    );

    cdiv_counter #(.RST_LOW(RST_LOW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .sync_eff (sync_eff),
        .sh_cfg   (sh_cfg),
        .lvl      (div_lvl),
        .st       (core_st),
        .cnt      (core_cnt)
    );

    cdiv_outmux u_mux (
        .clk_in   (clk),
        .div_lvl  (div_lvl),
        .pdn      (chan_pdn),
        .direct   (chan_direct),
        .glob_sel (path_sel_glob),
        .bypass   (sh_cfg.bypass),
        .ign_sync (sh_cfg.ign_sync),
        .frc_lvl  (sh_cfg.frc_lvl),
        .frc_en   (force_en),
        .out      (clk_out)
    );
endmodule

// File: rtl/cdiv_checker.sv
module cdiv_checker
    import cdiv_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             sync_req,
    input logic             force_en,
    input logic             chan_pdn,
    input logic             chan_direct,
    input logic             clk_out,
    input div_cfg_t         sh_cfg,
    input logic             div_lvl,
    input div_st_t          core_st,
    input logic [SEQ_W-1:0] core_cnt
);
    AST_HALF_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!(sync_req && !sh_cfg.ign_sync) && core_st == DS_RUN && core_cnt != '0)
        |=> $stable(div_lvl)); // R1

    AST_HALF_ENDS: assert property (@(posedge clk) disable iff (rst)
        (!(sync_req && !sh_cfg.ign_sync) && !sh_cfg.bypass && core_st == DS_RUN && core_cnt == '0)
        |=> (div_lvl != $past(div_lvl))); // R2

    AST_SYNC_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (sync_req && sh_cfg.ign_sync && core_st == DS_RUN && core_cnt != '0)
        |=> $stable(div_lvl)); // R4

    AST_FORCE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (force_en && sh_cfg.ign_sync && !sh_cfg.bypass && !chan_pdn && !chan_direct)
        |-> (clk_out == sh_cfg.frc_lvl)); // R5

    AST_SYNC_START: assert property (@(posedge clk) disable iff (rst)
        (sync_req && !sh_cfg.ign_sync)
        |=> (div_lvl == $past(sh_cfg.start_hi))); // R6

    AST_PDN_LOW: assert property (@(posedge clk) disable iff (rst)
        chan_pdn |-> !clk_out); // R10
endmodule

bind cdiv_channel cdiv_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .sync_req    (sync_req),
    .force_en    (force_en),
    .chan_pdn    (chan_pdn),
    .chan_direct (chan_direct),
    .clk_out     (clk_out),
    .sh_cfg      (sh_cfg),
    .div_lvl     (div_lvl),
    .core_st     (core_st),
    .core_cnt    (core_cnt)
);

// File: tb/sim_cdiv_channel.sv
`timescale 1ns/1ps
module sim_cdiv_channel;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sync_req = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_low = 4'd3, cfg_high = 4'd3, cfg_phase = 4'd0;
    logic       cfg_bypass = 1'b0, cfg_ign_sync = 1'b0, cfg_frc_lvl = 1'b0, cfg_start_hi = 1'b0;
    logic       force_en = 1'b0, chan_direct = 1'b0, chan_pdn = 1'b0, path_sel_glob = 1'b0;
    logic       clk_out;
    int         checks = 0;
    int         errors = 0;

    always #4 clk = ~clk;

    cdiv_channel u0 (.*);

    typedef struct packed {
        logic [3:0] l;
        logic [3:0] h;
        logic [3:0] p;
        logic       s;
        logic [5:0] ft;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{l:4'd1,  h:4'd1, p:4'd0, s:1'b0, ft:6'd2},
        '{l:4'd0,  h:4'd0, p:4'd0, s:1'b1, ft:6'd1},
        '{l:4'd2,  h:4'd5, p:4'd3, s:1'b0, ft:6'd6},
        '{l:4'd4,  h:4'd1, p:4'd2, s:1'b1, ft:6'd4},
        '{l:4'd15, h:4'd0, p:4'd1, s:1'b0, ft:6'd17}
    };

    function automatic logic exp_lvl(input int t, input int l, input int h, input int p, input logic s);
        int   seg = p + (s ? h : l) + 1;
        int   rem = t;
        logic v   = s;
        while (rem >= seg) begin
            rem = rem - seg;
            v   = ~v;
            seg = (v ? h : l) + 1;
        end
        return v;
    endfunction

    task automatic check(input string req, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", req, act, expv);
        end
    endtask

    task automatic put_cfg(input int l, input int h, input int p, input logic s,
                           input logic ign, input logic frc, input logic byp);
        cfg_low = 4'(l); cfg_high = 4'(h); cfg_phase = 4'(p); cfg_start_hi = s;
        cfg_ign_sync = ign; cfg_frc_lvl = frc; cfg_bypass = byp;
        cfg_we = 1'b1;
    endtask

    // mode 0 plain, 1 ignored sync pulse, 2 force bit without strobe,
    // 3 high count cut mid-low, 4 high count cut mid-high
    task automatic window(input int l, input int h, input int p, input logic s, input logic frc,
                          input int mode, input int n, input string req, output int first_tog);
        int bad = 0;
        logic a = 1'b0;
        logic e = 1'b0;
        first_tog = -1;
        @(negedge clk); #1;
        put_cfg(l, h, p, s, 1'b0, frc, 1'b0);
        sync_req = 1'b1;
        @(negedge clk); #1;
        cfg_we = 1'b0;
        @(negedge clk);
        for (int t = 0; t < n; t++) begin
            if (t > 0) @(negedge clk);
            a = clk_out;
            case (mode)
                3:       e = exp_lvl(t, l, 1, p, s);
                4:       e = (t < 8) ? exp_lvl(t, l, h, p, s) : exp_lvl(t - 8, l, 1, p, s);
                default: e = exp_lvl(t, l, h, p, s);
            endcase
            if (first_tog < 0 && a !== s) first_tog = t;
            if (a !== e && bad == 0) begin
                bad = 1;
                $display("FAIL %s: actual %0b expected %0b at cycle %0d", req, a, e, t);
            end
            #1;
            cfg_we = 1'b0;
            if (t == 0) sync_req = 1'b0;
            if ((mode == 1 || mode == 2) && t == 3) put_cfg(l, h, p, s, 1'b1, mode == 2, 1'b0);
            if (mode == 1 && t == 6) sync_req = 1'b1;
            if (mode == 1 && t == 7) sync_req = 1'b0;
            if (mode == 3 && t == 2) put_cfg(l, 1, p, s, 1'b0, frc, 1'b0);
            if (mode == 4 && t == 5) put_cfg(l, 1, p, s, 1'b0, frc, 1'b0);
        end
        checks++;
        errors += bad;
        @(negedge clk); #1;
        cfg_we = 1'b0; sync_req = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int ft;
        // R3: reset state and default waveform (low 4, high 4)
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        rst = 1'b0;
        begin
            int bad = 0;
            for (int t = 0; t < 16; t++) begin
                if (t > 0) @(negedge clk);
                if (clk_out !== exp_lvl(t, 3, 3, 0, 1'b0) && bad == 0) begin
                    bad = 1;
                    $display("FAIL R3: actual %0b expected %0b at cycle %0d", clk_out, exp_lvl(t, 3, 3, 0, 1'b0), t);
                end
            end
            checks++;
            errors += bad;
        end

        // R1 R2 R6 R7: table of restarts
        foreach (VECS[i]) begin
            window(VECS[i].l, VECS[i].h, VECS[i].p, VECS[i].s, 1'b0, 0, 40, "R1/R2/R6 table", ft);
            checks++;
            if (ft != int'(VECS[i].ft)) begin
                errors++;
                $display("FAIL R7: actual first edge %0d expected %0d", ft, VECS[i].ft);
            end
        end

        // R4: restart pulse while ignoring
        window(2, 2, 0, 1'b0, 1'b0, 1, 24, "R4", ft);
        // R12: force bit with no strobe
        window(3, 2, 0, 1'b0, 1'b0, 2, 24, "R12 no strobe", ft);
        // R11: high count change during low half and during high half
        window(3, 3, 0, 1'b0, 1'b0, 3, 20, "R11 mid-low", ft);
        window(3, 3, 0, 1'b0, 1'b0, 4, 20, "R11 mid-high", ft);
        // R12: strobe while sync obeyed, force bit set
        force_en = 1'b1;
        window(1, 2, 1, 1'b0, 1'b1, 0, 20, "R12 strobe without ignore", ft);

        // R5: forcing high then low
        @(negedge clk); #1;
        put_cfg(3, 3, 0, 1'b0, 1'b1, 1'b1, 1'b0);
        @(negedge clk); #1;
        cfg_we = 1'b0;
        repeat (3) @(negedge clk);
        check("R5 force high, low clk phase", clk_out, 1'b1);
        @(posedge clk); #2;
        check("R5 force high, high clk phase", clk_out, 1'b1);
        @(negedge clk); #1;
        put_cfg(3, 3, 0, 1'b0, 1'b1, 1'b0, 1'b0);
        @(negedge clk); #1;
        cfg_we = 1'b0;
        @(posedge clk); #2;
        check("R5 force low", clk_out, 1'b0);

        // R9: global select disables direct path (forced low underneath)
        chan_direct = 1'b1; path_sel_glob = 1'b1;
        @(posedge clk); #2;
        check("R9 direct overridden", clk_out, 1'b0);
        path_sel_glob = 1'b0;
        @(posedge clk); #2;
        check("R9 direct high phase", clk_out, 1'b1);
        @(negedge clk); #2;
        check("R9 direct low phase", clk_out, 1'b0);
        // R10: power-down beats direct path
        chan_pdn = 1'b1;
        @(posedge clk); #2;
        check("R10 pdn over direct", clk_out, 1'b0);
        chan_direct = 1'b0; chan_pdn = 1'b0; force_en = 1'b0;

        // R8: bypass passes the input clock
        @(negedge clk); #1;
        put_cfg(3, 3, 0, 1'b0, 1'b0, 1'b0, 1'b1);
        @(negedge clk); #1;
        cfg_we = 1'b0;
        @(posedge clk); #2;
        check("R8 bypass high phase", clk_out, 1'b1);
        @(negedge clk); #2;
        check("R8 bypass low phase", clk_out, 1'b0);
        chan_pdn = 1'b1;
        @(posedge clk); #2;
        check("R10 pdn over bypass", clk_out, 1'b0);
        chan_pdn = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule